// File: doc/BRIEF.md
# Carry-Save Tree Multiplier

This block multiplies two unsigned operands of `W` bits each (eight by default) and returns the full `2*W`-bit product. Each bit of `y` gates a copy of `x` to form one partial-product row. Row `j` is that gated copy shifted left by `j` places. The rows then pass through layers of 3:2 carry-save compressors. Each layer takes groups of three words and turns each group into a sum word and a carry word. No carry travels inside a layer. The carry word carries weight one place higher, so it is shifted left by one before the next layer. With eight rows the row count goes 8, 6, 4, 3, 2.

When two words are left, one carry-propagate adder adds them. This is the only point where a carry has to ripple. Any carry out of the top product bit is dropped, because the true product always fits in `2*W` bits. The product is captured in an output register, so `q` shows the product of the operands that were present at the previous rising clock edge.

Top module: `csa_tree_mul`

## Requirements
- R1: One clock edge after operands `x` and `y` are sampled, `q` equals the unsigned product `x*y`, full width with no truncation.
- R2: While `rst_n` is low, `q` is 0.
- R3: If either operand is 0, the registered product is 0.
- R4: If `y` is 1, the registered product equals `x` with zero extension, and the same holds with the roles of `x` and `y` swapped.
- R5: If `y` is a power of two 2^j, the registered product equals `x` shifted left by j places.
- R6: For the largest operands (all ones), the product is (2^W-1)^2, which is 0xFE01 for W=8. No product ever exceeds this bound.
- R7: Swapping `x` and `y` does not change the product.
- R8: While both operands stay unchanged across consecutive edges, `q` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the product register |
| rst_n | input | 1 | Asynchronous reset, active low; clears the product register |
| x | input | W | Multiplicand, unsigned |
| y | input | W | Multiplier, unsigned; bit j enables partial-product row j |
| q | output | 2*W | Registered unsigned product |

## Verification
A wrong bit inside one compressor layer, or a carry word that is not shifted, changes the sum of the words that remain. It therefore corrupts `q` on the very next edge for any operand pair that sets that bit. Every one of the 65536 operand pairs is applied, so every cell sees every combination of inputs that the block can produce. A missing or extra carry in the final adder shows up as a product that is off by a power of two. The directed operands (zero, one, powers of two, all ones) make it clear whether a row is placed or gated wrongly.

// File: rtl/csa_tree_mul.sv
module csa_tree_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] q
);
  localparam int PW = 2 * W;

  function automatic int rows_at(input int k);
    int n;
    n = W;
    for (int i = 0; i < k; i++) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  function automatic int layer_count();
    int n;
    int c;
    n = W;
    c = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + (n % 3);
      c++;
    end
    return c;
  endfunction

  localparam int NL = layer_count();

  logic [PW-1:0] rows [NL+1][W];
  logic [PW-1:0] op_a, op_b, sum_w;
  logic [PW-1:0] cy;

  for (genvar j = 0; j < W; j++) begin : g_pp
    assign rows[0][j] = PW'({W{y[j]}} & x) << j;
  end

  for (genvar k = 0; k < NL; k++) begin : g_layer
    localparam int NIN  = rows_at(k);
    localparam int NG   = NIN / 3;
    localparam int NOUT = rows_at(k + 1);
    for (genvar g = 0; g < NG; g++) begin : g_csa
      logic [PW-1:0] a, b, c;
      assign a = rows[k][3*g];
      assign b = rows[k][3*g+1];
      assign c = rows[k][3*g+2];
      assign rows[k+1][2*g]   = a ^ b ^ c;
      assign rows[k+1][2*g+1] = ((a & b) | (b & c) | (c & a)) << 1;
    end
    for (genvar r = 0; r < NIN % 3; r++) begin : g_pass
      assign rows[k+1][2*NG+r] = rows[k][3*NG+r];
    end
    for (genvar r = NOUT; r < W; r++) begin : g_idle
      assign rows[k+1][r] = '0;
    end
  end

  assign op_a  = rows[NL][0];
  assign op_b  = rows[NL][1];
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < PW; i++) begin : g_cpa
    assign sum_w[i] = op_a[i] ^ op_b[i] ^ cy[i];
    if (i < PW - 1) begin : g_c
      assign cy[i+1] = (op_a[i] & op_b[i]) | (cy[i] & (op_a[i] ^ op_b[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sum_w;
  end
endmodule

// File: rtl/csa_tree_mul_chk.sv
module csa_tree_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   x,
  input logic [W-1:0]   y,
  input logic [2*W-1:0] q
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] OPMAX = PW'({W{1'b1}});
  localparam logic [PW-1:0] PMAX  = OPMAX * OPMAX;

  a_r2_reset_clear: assert property (@(posedge clk) !rst_n |=> (q == '0 || !rst_n));

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q == PW'($past(x)) * PW'($past(y))));

  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (x == '0 || y == '0) |=> (q == '0));

  a_r4_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (y == W'(1)) |=> (q == PW'($past(x))));

  a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n) q <= PMAX);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(x) && $stable(y)) |=> $stable(q));
endmodule

bind csa_tree_mul csa_tree_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .x(x), .y(y), .q(q)
);

// File: tb/csa_tree_mul_test.sv
module csa_tree_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  x = '0;
  logic [7:0]  y = '0;
  logic [15:0] q;
  int n_run = 0;
  int n_fail = 0;

  csa_tree_mul #(.W(8)) uut (.clk(clk), .rst_n(rst_n), .x(x), .y(y), .q(q));

  always #4 clk = ~clk;

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc + ({8'h00, a} << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: x=%0d y=%0d q=%0d expected %0d", req, x, y, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input string req);
    @(negedge clk);
    x = a;
    y = b;
    @(negedge clk);
    check(req, q, ref_mul(a, b));
  endtask

  initial begin
    #(8 * 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [7:0]  ra, rb;
    void'($urandom(32'h5EED_0042));
    x = 8'hFF;
    y = 8'hFF;
    repeat (3) @(negedge clk);
    check("R2 reset", q, 16'h0000);
    rst_n = 1'b1;

    apply(8'd0, 8'd0, "R3 zero both");
    apply(8'd173, 8'd0, "R3 y zero");
    apply(8'd0, 8'd201, "R3 x zero");
    apply(8'd97, 8'd1, "R4 y one");
    apply(8'd1, 8'd233, "R4 x one");
    for (int j = 0; j < 8; j++) begin
      apply(8'hB7, 8'(1 << j), "R5 power of two");
      check("R5 shift", q, 16'hB7 << j);
    end
    apply(8'hFF, 8'hFF, "R6 max");
    check("R6 max value", q, 16'hFE01);
    apply(8'hFF, 8'h01, "R6 edge");
    apply(8'h80, 8'h80, "R6 top rows");

    apply(8'd37, 8'd211, "R7 order a");
    held = q;
    apply(8'd211, 8'd37, "R7 order b");
    check("R7 commute", q, held);

    apply(8'd123, 8'd45, "R8 setup");
    held = q;
    repeat (4) begin
      @(negedge clk);
      check("R8 hold", q, held);
    end

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(8'(a), 8'(b), "R1 exhaustive");

    repeat (500) begin
      ra = 8'($urandom);
      rb = 8'($urandom);
      apply(ra, rb, "R1 random");
      held = q;
      apply(rb, ra, "R7 random swap");
      check("R7 random commute", q, held);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule